// File: doc/BRIEF.md
# Lane-Count Vector Shifter

This unit shifts every element of a data vector by a count drawn from a second vector. The second vector is read as 64-bit lanes. Each lane holds one unsigned count. That count applies to every data element that sits inside the same 64-bit lane, whatever the element size. The unit performs three kinds of shift: arithmetic right, logical right and logical left. Elements are 8, 16 or 32 bits wide.

The caller presents a two-bit operation field, a two-bit size field and both vectors, then pulses `in_valid`. One cycle later the result appears with `out_valid`. An unsupported size or operation code raises `illegal` and returns a zeroed result. The vector width is a parameter and must be a multiple of 64.

Top module: `wide_shift_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `in_valid` was high, and low in the cycle after a cycle in which `in_valid` was low.
- R2: Operation code 2'b00 selects arithmetic right, 2'b01 selects logical right and 2'b11 selects logical left. Code 2'b10 is illegal.
- R3: Size code 0 selects 8-bit elements, 1 selects 16-bit elements and 2 selects 32-bit elements. Size code 3 is illegal.
- R4: An illegal operation or size code sets `illegal` together with `out_valid`, and the result is all zero. A legal strobe clears `illegal`.
- R5: Element i of size W uses as its count the whole 64-bit lane of `count_vec` at bits [64k+63:64k], where k = (i*W)/64.
- R6: An arithmetic right shift treats the element as signed. A count at or above W fills the element with copies of its sign bit.
- R7: Logical right and left shifts treat the element as unsigned and fill with zeros. A count at or above W gives zero.
- R8: A count is compared as a full 64-bit unsigned value. A count whose low bits are small but whose upper bits are set saturates; it is not reduced modulo W.
- R9: After reset, `out_valid`, `illegal` and `result_vec` are zero.
- R10: `result_vec` and `illegal` keep their values through cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| op_code | input | 2 | Shift kind (see R2) |
| size_code | input | 2 | Element size (see R3) |
| data_vec | input | VEC_W | Elements to shift |
| count_vec | input | VEC_W | One 64-bit count per lane |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result_vec | output | VEC_W | Shifted elements |
| illegal | output | 1 | Unsupported code seen on the last strobe |

## Verification
Within a single strobe, different lanes can take different count regimes in the same cycle. One lane may saturate while its neighbour shifts by W-1, 0 or an in-range amount. Directed vectors place 0, W-1, W and counts with only upper bits set side by side across lanes, and the random mix draws those classes independently for each lane. The bench judges each element against a reference function that reads the lane count from the lane that contains the element. A mistake at a lane or element boundary therefore shows up as a mismatch in a specific element.

// File: rtl/wsh_pkg.sv
// Shared definitions for the lane-count vector shifter.
// Assumes counts are carried in 64-bit lanes.
package wsh_pkg;
    localparam int LANE_W = 64;

    typedef enum logic [1:0] {
        OP_ASR = 2'b00,
        OP_LSR = 2'b01,
        OP_RSV = 2'b10,
        OP_LSL = 2'b11
    } shift_op_e;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } elem_size_e;
endpackage

// File: rtl/wsh_decode.sv
// Turns the raw operation and size fields into typed controls and a legal flag.
// Assumes nothing beyond the two 2-bit fields is decoded here.
module wsh_decode
    import wsh_pkg::*;
(
    input  logic [1:0]  op_code,
    input  logic [1:0]  size_code,
    output shift_op_e   op,
    output elem_size_e  size,
    output logic        legal
);
    // Cast the fields and reject the reserved operation and the 64-bit size.
    always_comb begin
        op    = shift_op_e'(op_code);
        size  = elem_size_e'(size_code);
        legal = (op != OP_RSV) && (size != SZ_D);
    end
endmodule

// File: rtl/wsh_elem.sv
// Shifts one element of EW bits by a full 64-bit unsigned count.
// Assumes EW is a power of two no larger than 32.
module wsh_elem
    import wsh_pkg::*;
#(
    parameter int EW = 8
) (
    input  shift_op_e        op,
    input  logic [EW-1:0]    din,
    input  logic [LANE_W-1:0] cnt,
    output logic [EW-1:0]    dout
);
    localparam int AW = $clog2(EW);

    logic          sat;
    logic [AW-1:0] amt;

    // Flag counts at or above the element width and pick the effective amount.
    always_comb begin
        sat = |cnt[LANE_W-1:AW];
        amt = sat ? AW'(EW - 1) : cnt[AW-1:0];
    end

    // Apply the selected shift with the fill rule for saturated counts.
    always_comb begin
        case (op)
            OP_ASR:  dout = EW'($signed(din) >>> amt);
            OP_LSR:  dout = sat ? '0 : (din >> amt);
            OP_LSL:  dout = sat ? '0 : (din << amt);
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/wsh_lane.sv
// Processes one 64-bit lane: all three element sizes in parallel, one selected.
// Assumes the count for every element in the lane is the lane's single count.
module wsh_lane
    import wsh_pkg::*;
(
    input  shift_op_e          op,
    input  elem_size_e         size,
    input  logic [LANE_W-1:0]  din,
    input  logic [LANE_W-1:0]  cnt,
    output logic [LANE_W-1:0]  dout
);
    localparam int NSIZES = 3;

    logic [LANE_W-1:0] by_size [NSIZES];

    for (genvar g = 0; g < NSIZES; g++) begin : g_size
        localparam int EW = 8 << g;
        localparam int NE = LANE_W / EW;
        logic [LANE_W-1:0] lane_res;
        for (genvar e = 0; e < NE; e++) begin : g_elem
            wsh_elem #(.EW(EW)) u_elem (
                .op   (op),
                .din  (din[e*EW +: EW]),
                .cnt  (cnt),
                .dout (lane_res[e*EW +: EW])
            );
        end
        assign by_size[g] = lane_res;
    end

    // Pick the result that matches the requested element size.
    always_comb begin
        case (size)
            SZ_B:    dout = by_size[0];
            SZ_H:    dout = by_size[1];
            SZ_W:    dout = by_size[2];
            default: dout = '0;
        endcase
    end
endmodule

// File: rtl/wide_shift_unit.sv
// Top level: decodes the fields, shifts every 64-bit lane and registers the result.
// Assumes VEC_W is a multiple of 64; result and flag load only on a strobe.
module wide_shift_unit
    import wsh_pkg::*;
#(
    parameter int VEC_W = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op_code,
    input  logic [1:0]       size_code,
    input  logic [VEC_W-1:0] data_vec,
    input  logic [VEC_W-1:0] count_vec,
    output logic             out_valid,
    output logic [VEC_W-1:0] result_vec,
    output logic             illegal
);
    localparam int NLANES = VEC_W / LANE_W;

    shift_op_e        op;
    elem_size_e       size;
    logic             legal;
    logic [VEC_W-1:0] shifted;

    wsh_decode u_dec (
        .op_code   (op_code),
        .size_code (size_code),
        .op        (op),
        .size      (size),
        .legal     (legal)
    );

    for (genvar k = 0; k < NLANES; k++) begin : g_lane
        wsh_lane u_lane (
            .op   (op),
            .size (size),
            .din  (data_vec[k*LANE_W +: LANE_W]),
            .cnt  (count_vec[k*LANE_W +: LANE_W]),
            .dout (shifted[k*LANE_W +: LANE_W])
        );
    end

    // Output strobe follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Capture the result and illegal flag on each strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_vec <= '0;
            illegal    <= 1'b0;
        end else if (in_valid) begin
            result_vec <= legal ? shifted : '0;
            illegal    <= !legal;
        end
    end
endmodule

// File: rtl/wsh_checker.sv
// Temporal properties of the shifter, attached to every instance by bind.
// Assumes the top's port names.
module wsh_checker #(
    parameter int VEC_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [1:0]       op_code,
    input logic [1:0]       size_code,
    input logic [VEC_W-1:0] data_vec,
    input logic [VEC_W-1:0] count_vec,
    input logic             out_valid,
    input logic [VEC_W-1:0] result_vec,
    input logic             illegal
);
    p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_size_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'b11) |=> (illegal && out_valid));
    p_op_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b10) |=> (illegal && out_valid));
    p_zero_on_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && illegal) |-> (result_vec == '0));
    p_asr_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b00 && size_code != 2'b11 && count_vec == '0)
        |=> (result_vec == $past(data_vec)));
    p_lsl_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 2'b11 && size_code != 2'b11 && count_vec[63:0] >= 64'd32)
        |=> (result_vec[63:0] == 64'd0));
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result_vec) && $stable(illegal)));
endmodule

bind wide_shift_unit wsh_checker #(.VEC_W(VEC_W)) u_wsh_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .size_code  (size_code),
    .data_vec   (data_vec),
    .count_vec  (count_vec),
    .out_valid  (out_valid),
    .result_vec (result_vec),
    .illegal    (illegal)
);

// File: tb/tb_wide_shift_unit.sv
// Self-checking bench: directed corner vectors plus seeded random mix.
module tb_wide_shift_unit;
    localparam int VW = 256;
    localparam int NL = VW / 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    op_code = '0;
    logic [1:0]    size_code = '0;
    logic [VW-1:0] data_vec = '0;
    logic [VW-1:0] count_vec = '0;
    logic          out_valid;
    logic [VW-1:0] result_vec;
    logic          illegal;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    wide_shift_unit #(.VEC_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .size_code(size_code), .data_vec(data_vec), .count_vec(count_vec),
        .out_valid(out_valid), .result_vec(result_vec), .illegal(illegal)
    );

    // Reference shift built from the requirements.
    function automatic logic [VW-1:0] ref_shift(input logic [1:0] op, input logic [1:0] sz,
                                                input logic [VW-1:0] d, input logic [VW-1:0] c);
        logic [VW-1:0] out;
        out = '0;
        if (sz == 2'd3 || op == 2'b10) return out;
        for (int e = 0; e < VW / (8 << sz); e++) begin
            int w;
            logic [63:0] cnt, mask, x, r, sx;
            w    = 8 << sz;
            cnt  = c[((e * w) / 64) * 64 +: 64];
            mask = (64'd1 << w) - 64'd1;
            x    = 64'(d >> (e * w)) & mask;
            if (op == 2'b11)      r = (cnt >= 64'(w)) ? 64'd0 : ((x << cnt) & mask);
            else if (op == 2'b01) r = (cnt >= 64'(w)) ? 64'd0 : (x >> cnt);
            else begin
                sx = x[w-1] ? (x | ~mask) : x;
                r  = 64'($signed(sx) >>> ((cnt >= 64'(w)) ? 64'(w - 1) : cnt)) & mask;
            end
            out = out | (VW'(r) << (e * w));
        end
        return out;
    endfunction

    // Pick a lane count from the corner classes for element width w.
    function automatic logic [63:0] pick_count(input int w);
        case ($urandom % 6)
            0: return 64'd0;
            1: return 64'(w - 1);
            2: return 64'(w);
            3: return {$urandom, $urandom} | 64'h8000_0000_0000_0000;
            4: return {32'h1, 32'd1};
            default: return 64'($urandom % w);
        endcase
    endfunction

    task automatic check_vec(input string tag, input logic [VW-1:0] got, input logic [VW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic got, input logic exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%b exp=%b", tag, got, exp);
        end
    endtask

    // Drive one strobe, then sample the registered outputs at the following negedge.
    task automatic run_one(input string tag, input logic [1:0] op, input logic [1:0] sz,
                           input logic [VW-1:0] d, input logic [VW-1:0] c);
        logic bad;
        @(negedge clk);
        op_code = op; size_code = sz; data_vec = d; count_vec = c; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        bad = (sz == 2'd3) || (op == 2'b10);
        check_bit({tag, " out_valid R1"}, out_valid, 1'b1);
        check_bit({tag, " illegal R4"}, illegal, bad);
        check_vec(tag, result_vec, ref_shift(op, sz, d, c));
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        logic [VW-1:0] d, c, held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check_bit("R9 out_valid", out_valid, 1'b0);
        check_bit("R9 illegal", illegal, 1'b0);
        check_vec("R9 result", result_vec, '0);
        rst_n = 1'b1;

        d = {8{32'hF08C_7F81}};
        c = {64'hFFFF_FFFF_FFFF_FFFF, 64'd8, 64'd7, 64'd0};
        run_one("R6 asr byte", 2'b00, 2'd0, d, c);
        run_one("R7 lsr byte", 2'b01, 2'd0, d, c);
        c = {64'h8000_0000_0000_0000, 64'd16, 64'd15, 64'd0};
        run_one("R6 asr half", 2'b00, 2'd1, d, c);
        run_one("R7 lsl half", 2'b11, 2'd1, d, c);
        c = {64'h0000_0001_0000_0001, 64'd32, 64'd31, 64'd0};
        run_one("R8 lsl word", 2'b11, 2'd2, d, c);
        run_one("R8 asr word", 2'b00, 2'd2, d, c);
        c = {64'd3, 64'd2, 64'd1, 64'd4};
        run_one("R5 lane counts", 2'b01, 2'd0, d, c);
        run_one("R2 lsl mixed", 2'b11, 2'd2, d, c);
        run_one("R3 size three", 2'b01, 2'd3, d, c);
        run_one("R2 reserved op", 2'b10, 2'd1, d, c);

        run_one("R4 clear", 2'b00, 2'd0, d, c);
        held = result_vec;
        repeat (2) @(negedge clk);
        check_bit("R1 idle out_valid", out_valid, 1'b0);
        check_vec("R10 hold", result_vec, held);
        check_bit("R10 hold illegal", illegal, 1'b0);

        for (int t = 0; t < 400; t++) begin
            logic [1:0] op, sz;
            op = 2'($urandom % 4);
            sz = 2'(($urandom % 8 == 0) ? 3 : ($urandom % 3));
            for (int k = 0; k < VW / 32; k++) d[k*32 +: 32] = $urandom;
            for (int k = 0; k < NL; k++) c[k*64 +: 64] = pick_count(8 << ((sz == 2'd3) ? 2 : sz));
            run_one("R5 random", op, sz, d, c);
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule